// File: doc/BRIEF.md
# Two-Level Packet Round-Robin Arbiter

This block schedules one subcrossbar of a partitioned-crossbar switch. The subcrossbar is asymmetric: it has `N_IN` inputs, one read port from each input memory, and `N_OUT` outputs, where `N_OUT` is the number of switch outputs divided by the number of subcrossbars. Each input memory keeps `N_Q` queues. For every queue the arbiter receives three things: whether a head packet for this output group is waiting, whether the downstream queue-level flow control permits sending (the on/off flag), and which local output the head packet targets.

Arbitration has two round-robin levels. In the first level, each memory whose read port is idle selects one eligible queue. In the second level, each idle output selects one memory from those whose candidate targets that output. A connection lasts for the whole packet. It is released only when the output reports end of packet, and the output and read port are then free for arbitration in the next cycle. The outputs drive the crosspoint select of each output, the busy state and queue of each read port, and a one-cycle start pulse for each queue that is granted.

Top module: `pkt_rr_arbiter`

## Requirements
- R1: After reset no output is connected, no read port is busy and no grant pulse is raised, and every round-robin pointer starts at index 0.
- R2: Queue q of memory i (bit i*N_Q+q of `req_valid` and `xon`) can be granted only when both of its bits are 1, its read port is idle, and the output in its `req_dest` field (bits (i*N_Q+q)*OW and up, OW = clog2(N_OUT)) is idle.
- R3: Inside a memory, queues are searched starting at a per-memory pointer. The pointer moves to one past the chosen queue only when that memory wins a connection. Otherwise it keeps its value.
- R4: For each output, memories are searched starting at a per-output pointer. The pointer moves to one past the winning memory only when that output is granted.
- R5: Once a connection is made, the output stays connected to the same memory (`conn_sel` field o, bits o*IW and up, IW = clog2(N_IN)), and the port keeps the same queue, until end of packet.
- R6: A pulse on `eop[o]` while output o is connected frees that output and its read port at the next edge. Neither can be granted again in the same cycle as the pulse. Both can be granted in the cycle after.
- R7: An output is connected to at most one memory, and a read port feeds at most one output.
- R8: Each new connection raises `gnt_pulse` bit i*N_Q+q for exactly one cycle, in the first cycle the connection is visible. At most one bit per memory is raised.
- R9: An `eop` pulse on an idle output has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_IN*N_Q | Head packet for this output group is present, per queue |
| xon | input | N_IN*N_Q | Queue-level flow control permits sending |
| req_dest | input | N_IN*N_Q*clog2(N_OUT) | Local output targeted by each head packet |
| eop | input | N_OUT | End-of-packet strobe per output |
| conn_valid | output | N_OUT | Output currently connected |
| conn_sel | output | N_OUT*clog2(N_IN) | Crosspoint select: memory driving each output |
| port_busy | output | N_IN | Read port in use |
| port_queue | output | N_IN*clog2(N_Q) | Queue being read on each busy port |
| gnt_pulse | output | N_IN*N_Q | One-cycle start pulse for each granted queue |

## Verification
The hardest case to produce is a release and a new request for the same output in the same cycle, followed by a correct round-robin handover on the cycle after. The stimulus keeps a packet running and requests the same output from a second memory while the end-of-packet strobe fires. A sweep then drives every request pattern from idle, and afterwards a long pseudo-random run. During that run, end-of-packet strobes are raised only for outputs that the model shows as busy. This leaves the pointers in many different positions, so queue and memory search orders are both exercised when they start from non-zero pointers.

// File: rtl/pkt_rr_arbiter.sv
module pkt_rr_arbiter #(
  parameter int N_IN  = 4,
  parameter int N_Q   = 2,
  parameter int N_OUT = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [N_IN*N_Q-1:0]                  req_valid,
  input  logic [N_IN*N_Q-1:0]                  xon,
  input  logic [N_IN*N_Q*$clog2(N_OUT)-1:0]    req_dest,
  input  logic [N_OUT-1:0]                     eop,
  output logic [N_OUT-1:0]                     conn_valid,
  output logic [N_OUT*$clog2(N_IN)-1:0]        conn_sel,
  output logic [N_IN-1:0]                      port_busy,
  output logic [N_IN*$clog2(N_Q)-1:0]          port_queue,
  output logic [N_IN*N_Q-1:0]                  gnt_pulse
);
  localparam int IW = $clog2(N_IN);
  localparam int QW = $clog2(N_Q);
  localparam int OW = $clog2(N_OUT);
  localparam int NR = N_IN * N_Q;

  logic [QW-1:0] qptr [N_IN];
  logic [IW-1:0] optr [N_OUT];
  logic [IW-1:0] src_r [N_OUT];
  logic [QW-1:0] q_r [N_IN];
  logic [N_OUT-1:0] obusy;
  logic [N_IN-1:0]  pbusy;
  logic [NR-1:0]    gnt_r;

  // level 1: one candidate queue per idle read port
  logic [N_IN-1:0] cv;
  logic [QW-1:0]   cq [N_IN];
  logic [OW-1:0]   cd [N_IN];

  always_comb begin
    for (int i = 0; i < N_IN; i++) begin
      cv[i] = 1'b0;
      cq[i] = '0;
      cd[i] = '0;
      for (int k = 0; k < N_Q; k++) begin
        int j;
        logic [OW-1:0] d;
        j = (int'(qptr[i]) + k) % N_Q;
        d = req_dest[(i*N_Q+j)*OW +: OW];
        if (!cv[i] && !pbusy[i] && req_valid[i*N_Q+j] && xon[i*N_Q+j] &&
            int'(d) < N_OUT && !obusy[d]) begin
          cv[i] = 1'b1;
          cq[i] = QW'(j);
          cd[i] = d;
        end
      end
    end
  end

  // level 2: one winning memory per idle output
  logic [N_OUT-1:0] ow;
  logic [IW-1:0]    wi [N_OUT];
  logic [N_IN-1:0]  won;
  logic [N_IN-1:0]  rel_p;

  always_comb begin
    won   = '0;
    rel_p = '0;
    for (int o = 0; o < N_OUT; o++) begin
      ow[o] = 1'b0;
      wi[o] = '0;
      for (int k = 0; k < N_IN; k++) begin
        int i;
        i = (int'(optr[o]) + k) % N_IN;
        if (!ow[o] && !obusy[o] && cv[i] && int'(cd[i]) == o) begin
          ow[o] = 1'b1;
          wi[o] = IW'(i);
        end
      end
      if (ow[o]) won[wi[o]] = 1'b1;
      if (obusy[o] && eop[o]) rel_p[src_r[o]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      obusy <= '0;
      pbusy <= '0;
      gnt_r <= '0;
      for (int o = 0; o < N_OUT; o++) begin
        optr[o]  <= '0;
        src_r[o] <= '0;
      end
      for (int i = 0; i < N_IN; i++) begin
        qptr[i] <= '0;
        q_r[i]  <= '0;
      end
    end else begin
      for (int o = 0; o < N_OUT; o++) begin
        obusy[o] <= (obusy[o] && !eop[o]) || ow[o];
        if (ow[o]) begin
          src_r[o] <= wi[o];
          optr[o]  <= (int'(wi[o]) == N_IN-1) ? '0 : wi[o] + 1'b1;
        end
      end
      for (int i = 0; i < N_IN; i++) begin
        pbusy[i] <= (pbusy[i] && !rel_p[i]) || won[i];
        if (won[i]) begin
          q_r[i]  <= cq[i];
          qptr[i] <= (int'(cq[i]) == N_Q-1) ? '0 : cq[i] + 1'b1;
        end
        for (int j = 0; j < N_Q; j++)
          gnt_r[i*N_Q+j] <= won[i] && int'(cq[i]) == j;
      end
    end
  end

  assign conn_valid = obusy;
  assign port_busy  = pbusy;
  assign gnt_pulse  = gnt_r;

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    assign conn_sel[o*IW +: IW] = src_r[o];

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      obusy[o] && !eop[o] |=> obusy[o] && $stable(src_r[o]));

    // R6
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      obusy[o] && eop[o] |=> !obusy[o]);

    for (genvar b = o + 1; b < N_OUT; b++) begin : g_pair
      // R7
      one_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        obusy[o] && obusy[b] |-> src_r[o] != src_r[b]);
    end
  end

  for (genvar i = 0; i < N_IN; i++) begin : g_port
    assign port_queue[i*QW +: QW] = q_r[i];

    // R8
    pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_r[i*N_Q +: N_Q]));

    // R2
    pulse_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      |gnt_r[i*N_Q +: N_Q] |-> pbusy[i]);
  end
endmodule

// File: tb/pkt_rr_arbiter_bench.sv
module pkt_rr_arbiter_bench;
  localparam int NI = 4;
  localparam int NQ = 2;
  localparam int NO = 2;
  localparam int NR = NI * NQ;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NR-1:0] req_valid = '0;
  logic [NR-1:0] xon = '0;
  logic [NR-1:0] req_dest = '0;
  logic [NO-1:0] eop = '0;
  logic [NO-1:0] conn_valid;
  logic [NO*2-1:0] conn_sel;
  logic [NI-1:0] port_busy;
  logic [NI-1:0] port_queue;
  logic [NR-1:0] gnt_pulse;

  int total = 0;
  int bad = 0;

  int mb [NI];
  int mq [NI];
  int qp [NI];
  int ob [NO];
  int os [NO];
  int op [NO];
  logic [NR-1:0] eg;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  pkt_rr_arbiter #(.N_IN(NI), .N_Q(NQ), .N_OUT(NO)) u_pkt_rr_arbiter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .xon(xon),
    .req_dest(req_dest), .eop(eop), .conn_valid(conn_valid),
    .conn_sel(conn_sel), .port_busy(port_busy), .port_queue(port_queue),
    .gnt_pulse(gnt_pulse)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NI; i++) begin mb[i] = 0; mq[i] = 0; qp[i] = 0; end
    for (int o = 0; o < NO; o++) begin ob[o] = 0; os[o] = 0; op[o] = 0; end
    eg = '0;
  endtask

  task automatic compare();
    for (int o = 0; o < NO; o++) begin
      chk("R5 R6 conn_valid", int'(conn_valid[o]), ob[o]);
      if (ob[o] != 0) chk("R4 conn_sel", int'(conn_sel[o*2 +: 2]), os[o]);
    end
    for (int i = 0; i < NI; i++) begin
      chk("R2 port_busy", int'(port_busy[i]), mb[i]);
      if (mb[i] != 0) chk("R3 port_queue", int'(port_queue[i]), mq[i]);
    end
    chk("R8 gnt_pulse", int'(gnt_pulse), int'(eg));
    if (conn_valid == 2'b11)
      chk("R7 distinct sel", int'(conn_sel[1:0] != conn_sel[3:2]), 1);
  endtask

  task automatic step(input logic [NR-1:0] rv, input logic [NR-1:0] xo,
                      input logic [NR-1:0] ds, input logic [NO-1:0] e);
    int cv [NI];
    int cq [NI];
    int cd [NI];
    int owin [NO];
    int wi [NO];
    req_valid = rv; xon = xo; req_dest = ds; eop = e;
    for (int i = 0; i < NI; i++) begin
      cv[i] = 0; cq[i] = 0; cd[i] = 0;
      if (mb[i] == 0)
        for (int k = 0; k < NQ; k++) begin
          int j;
          j = (qp[i] + k) % NQ;
          if (cv[i] == 0 && rv[i*NQ+j] && xo[i*NQ+j] && ob[ds[i*NQ+j]] == 0) begin
            cv[i] = 1; cq[i] = j; cd[i] = int'(ds[i*NQ+j]);
          end
        end
    end
    for (int o = 0; o < NO; o++) begin
      owin[o] = 0; wi[o] = 0;
      if (ob[o] == 0)
        for (int k = 0; k < NI; k++) begin
          int i;
          i = (op[o] + k) % NI;
          if (owin[o] == 0 && cv[i] != 0 && cd[i] == o) begin
            owin[o] = 1; wi[o] = i;
          end
        end
    end
    for (int o = 0; o < NO; o++)
      if (ob[o] != 0 && e[o]) begin ob[o] = 0; mb[os[o]] = 0; end
    eg = '0;
    for (int o = 0; o < NO; o++)
      if (owin[o] != 0) begin
        ob[o] = 1; os[o] = wi[o]; op[o] = (wi[o] + 1) % NI;
        mb[wi[o]] = 1; mq[wi[o]] = cq[wi[o]]; qp[wi[o]] = (cq[wi[o]] + 1) % NQ;
        eg[wi[o]*NQ + cq[wi[o]]] = 1'b1;
      end
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic next_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    chk("R1 conn_valid", int'(conn_valid), 0);
    chk("R1 port_busy", int'(port_busy), 0);
    chk("R1 gnt_pulse", int'(gnt_pulse), 0);

    // R9: eop on idle outputs does nothing
    step('0, '1, '0, 2'b11);
    chk("R9 conn_valid", int'(conn_valid), 0);
    chk("R9 port_busy", int'(port_busy), 0);

    // R6: release and same-cycle request for the freed output
    step(8'b0000_0001, '1, '0, 2'b00);
    chk("R6 setup conn", int'(conn_valid[0]), 1);
    chk("R8 first pulse", int'(gnt_pulse), 1);
    step(8'b0000_0100, '1, '0, 2'b01);
    chk("R6 no same-cycle regrant", int'(conn_valid[0]), 0);
    step(8'b0000_0100, '1, '0, 2'b00);
    chk("R6 regrant next cycle", int'(conn_valid[0]), 1);
    chk("R6 new source", int'(conn_sel[1:0]), 1);
    step('0, '1, '0, 2'b11);

    // R2: xon low blocks; R3 pointer of memory 0 now at queue 1
    step(8'b0000_0011, 8'b1111_1100, 8'b0000_0010, 2'b00);
    chk("R2 xon off", int'(port_busy[0]), 0);
    step(8'b0000_0011, '1, 8'b0000_0010, 2'b00);
    chk("R3 pointer order", int'(port_queue[0]), 1);
    step('0, '1, '0, 2'b11);

    // sweep every request pattern from idle
    for (int p = 0; p < 256; p++) begin
      step(p[7:0], '1, p[7:0] ^ 8'h5A, 2'b00);
      step(p[7:0], '1, p[7:0] ^ 8'h5A, 2'b00);
      step('0, '1, '0, 2'b11);
    end

    // pseudo-random run, eop only on busy outputs
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] rv;
      logic [7:0] xo;
      logic [7:0] ds;
      logic [1:0] e;
      next_rand(); rv = lfsr[7:0];
      next_rand(); xo = lfsr[7:0] | lfsr[15:8];
      next_rand(); ds = lfsr[7:0];
      next_rand();
      e[0] = (ob[0] != 0) && lfsr[1:0] == 2'b00;
      e[1] = (ob[1] != 0) && lfsr[3:2] == 2'b00;
      step(rv, xo, ds, e);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule